// File: doc/BRIEF.md
# Serial Transmit Path with Frame-Mode FIFO

This block is the transmit half of an asynchronous serial port. Software-side logic pushes 9-bit words into a 16-entry queue. A serializer takes words from the queue one at a time and sends each one on `txd` as a frame: a low start bit, a payload sent least significant bit first, and then a high stop period. The timing of every frame comes from an external oversample tick. A data bit lasts 16 ticks, and the stop period can be set in half-bit steps.

A 3-bit frame-mode field selects the payload. The choices are 8 data bits, 7 data bits plus parity, 8 data bits plus parity, 9 data bits, or 8 data bits plus a wake-up bit. A single control bit selects odd or even parity. When flow control is enabled, an active-low clear-to-send input holds back new frames. The block reports three status flags: empty, at least half empty, and full. A flush strobe discards every queued word. The mode, parity sense and stop length are captured when a frame starts, so changing them mid-frame has no effect on that frame.

Top module: `uart_tx_fifo`

## Requirements
- R1: After reset, `txd` is 1, `tx_empty` is 1, `tx_half` is 1 and `tx_full` is 0.
- R2: Each frame is a 0 start bit followed by the payload sent LSB first. Each start or payload bit lasts exactly 16 `tick` pulses. `txd` is 1 whenever no frame is in progress.
- R3: The frame mode selects the payload from the stored word `d`:
  - 3'b001: `d[7:0]`.
  - 3'b011: `d[6:0]` followed by one parity bit.
  - 3'b100: `d[8:0]`.
  - 3'b101: `d[7:0]` followed by the wake-up bit `d[8]`.
  - 3'b111: `d[7:0]` followed by one parity bit.
  - Any other code is handled as 3'b001.
- R4: The parity bit is the XOR of the transmitted data bits when `par_odd`=0 (even parity), and its complement when `par_odd`=1 (odd parity).
- R5: After the payload, `txd` stays 1 for a stop period set by `stop_len`:
  - 2'b00: 8 ticks.
  - 2'b01: 16 ticks.
  - 2'b10: 24 ticks.
  - 2'b11: 32 ticks.

  The next frame can start at the earliest in the cycle after the stop period ends.
- R6: The queue holds 16 words and sends them in write order. `tx_empty` is 1 when the queue holds no words and no frame is in progress. `tx_half` is 1 when the queue holds 8 or fewer words. `tx_full` is 1 when it holds 16.
- R7: A write while `tx_full` is 1 is dropped. This holds even if a frame takes a word from the queue in the same cycle.
- R8: While `cts_en`=1 and `cts_n`=1, no new frame starts. A frame already in progress still completes.
- R9: A `flush` pulse empties the queue by the next cycle. A write in the same cycle as the flush is dropped. A frame in progress still completes.
- R10: A frame starts on the first clock edge at which the serializer is idle, the queue holds a word, and R8 does not block it. `txd` falls in the next cycle. Mode, parity sense and stop length are captured at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 9 | Word to queue |
| flush | input | 1 | Discard all queued words |
| frame_mode | input | 3 | Payload format select |
| stop_len | input | 2 | Stop period in half-bit steps |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cts_en | input | 1 | Enables clear-to-send gating |
| cts_n | input | 1 | Active-low clear-to-send |
| tick | input | 1 | Oversample tick, 16 per bit |
| txd | output | 1 | Serial output line |
| tx_empty | output | 1 | Queue and serializer both empty |
| tx_half | output | 1 | Queue holds 8 or fewer words |
| tx_full | output | 1 | Queue holds 16 words |

## Verification
A wrong queue count shows up in the same cycle on the status flags. A wrong read pointer, or the wrong choice of payload or parity, shows up on `txd` within one bit time of the faulty bit, which is at most 16 ticks. Errors in the tick counter or the stop length move the next frame's start edge. The bench therefore compares `txd` and all three flags against a behavioural model on every clock, so the first cycle of divergence is reported.

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [8:0] wr_data,
  input  logic       flush,
  input  logic [2:0] frame_mode,
  input  logic [1:0] stop_len,
  input  logic       par_odd,
  input  logic       cts_en,
  input  logic       cts_n,
  input  logic       tick,
  output logic       txd,
  output logic       tx_empty,
  output logic       tx_half,
  output logic       tx_full
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [8:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt_q;
  logic          busy, stop_ph;
  logic [4:0]    tcnt, stop_lim;
  logic [3:0]    nleft;
  logic [9:0]    sh;
  logic [12:0]   frame;

  wire full  = (cnt_q == CW'(DEPTH));
  wire start = !busy && (cnt_q != '0) && !(cts_en && cts_n);
  wire push  = wr_en && !full && !flush;

  function automatic logic [12:0] build(input logic [8:0] d, input logic [2:0] m, input logic odd);
    case (m)
      3'b011:         return {4'd8, 1'b0, ^d[6:0] ^ odd, d[6:0]};
      3'b111:         return {4'd9, ^d[7:0] ^ odd, d[7:0]};
      3'b100, 3'b101: return {4'd9, d};
      default:        return {4'd8, 1'b0, d[7:0]};
    endcase
  endfunction

  assign frame = build(mem[rp], frame_mode, par_odd);

  always_ff @(posedge clk) if (push) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt_q <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt_q <= '0;
    end else begin
      if (push)  wp <= wp + 1'b1;
      if (start) rp <= rp + 1'b1;
      cnt_q <= cnt_q + CW'(push) - CW'(start);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; stop_ph <= 1'b0; tcnt <= '0;
      sh <= '1; nleft <= '0; stop_lim <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      stop_ph  <= 1'b0;
      tcnt     <= '0;
      sh       <= {frame[8:0], 1'b0};
      nleft    <= frame[12:9] + 4'd1;
      stop_lim <= {stop_len, 3'b111};
    end else if (busy && tick) begin
      if (!stop_ph) begin
        if (tcnt == 5'd15) begin
          tcnt  <= '0;
          sh    <= {1'b1, sh[9:1]};
          nleft <= nleft - 4'd1;
          if (nleft == 4'd1) stop_ph <= 1'b1;
        end else tcnt <= tcnt + 5'd1;
      end else if (tcnt == stop_lim) begin
        busy <= 1'b0; stop_ph <= 1'b0; tcnt <= '0;
      end else tcnt <= tcnt + 5'd1;
    end
  end

  assign txd      = !busy || stop_ph || sh[0];
  assign tx_empty = (cnt_q == '0) && !busy;
  assign tx_half  = (cnt_q <= CW'(DEPTH / 2));
  assign tx_full  = full;

  assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !flush && !start) |=> tx_full);
  assert_cts_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cts_en && cts_n) |=> !busy);
  assert_flush_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
  assert_start_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !txd);
  assert_stop_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop_ph) |=> txd);
  assert_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_half) && (cnt_q <= CW'(DEPTH)));
endmodule

// File: tb/tb_uart_tx_fifo.sv
module tb_uart_tx_fifo;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, flush = 0, par_odd = 0, cts_en = 0, cts_n = 0, tick = 0;
  logic [8:0] wr_data = '0;
  logic [2:0] frame_mode = 3'b001;
  logic [1:0] stop_len = 2'b01;
  logic txd, tx_empty, tx_half, tx_full;

  uart_tx_fifo dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .flush(flush),
    .frame_mode(frame_mode), .stop_len(stop_len), .par_odd(par_odd), .cts_en(cts_en),
    .cts_n(cts_n), .tick(tick), .txd(txd), .tx_empty(tx_empty), .tx_half(tx_half), .tx_full(tx_full));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  logic [8:0] q[$];
  bit bits[$];
  bit mbusy = 0, in_stop = 0;
  int tcnt = 0, stop_ticks = 0;

  always @(negedge clk) begin
    cyc++;
    tick <= (cyc % 2 == 0);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); bits.delete(); mbusy = 0; in_stop = 0; tcnt = 0;
    end else begin
      int pre;
      bit go;
      pre = q.size();
      go = !mbusy && pre > 0 && !(cts_en && cts_n);
      if (mbusy && tick) begin
        tcnt++;
        if (!in_stop) begin
          if (tcnt == 16) begin
            tcnt = 0; void'(bits.pop_front());
            if (bits.size() == 0) in_stop = 1;
          end
        end else if (tcnt == stop_ticks) begin
          mbusy = 0; in_stop = 0; tcnt = 0;
        end
      end
      if (go) begin
        logic [8:0] d;
        int n;
        bit p;
        d = q.pop_front();
        bits.delete(); bits.push_back(1'b0);
        n = (frame_mode == 3'b011) ? 7 : (frame_mode == 3'b100 || frame_mode == 3'b101) ? 9 : 8;
        p = par_odd;
        for (int i = 0; i < n; i++) begin bits.push_back(d[i]); p ^= d[i]; end
        if (frame_mode == 3'b011 || frame_mode == 3'b111) bits.push_back(p);
        mbusy = 1; in_stop = 0; tcnt = 0;
        stop_ticks = 8 * (int'(stop_len) + 1);
      end
      if (flush) q.delete();
      else if (wr_en && pre < 16) q.push_back(wr_data);
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      check(cur_req, "txd", txd, (!mbusy || in_stop) ? 1'b1 : logic'(bits[0]));
      check("R6", "tx_empty", tx_empty, q.size() == 0 && !mbusy);
      check("R6", "tx_half", tx_half, q.size() <= 8);
      check("R6", "tx_full", tx_full, q.size() == 16);
    end
  end

  task automatic put(logic [8:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((q.size() != 0 || mbusy) && guard < 20000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic mode_run(logic [2:0] m, logic odd, logic [8:0] d);
    @(negedge clk); frame_mode = m; par_odd = odd;
    put(d); drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "txd", txd, 1'b1);
    check("R1", "tx_empty", tx_empty, 1'b1);
    check("R1", "tx_half", tx_half, 1'b1);
    check("R1", "tx_full", tx_full, 1'b0);
    rst_n = 1;
    @(negedge clk);

    cur_req = "R2";
    put(9'h0A5); put(9'h03C); drain();

    cur_req = "R3";
    mode_run(3'b100, 0, 9'h1A5);
    mode_run(3'b101, 0, 9'h0F3);
    mode_run(3'b011, 0, 9'h055);
    mode_run(3'b111, 0, 9'h0C7);
    mode_run(3'b000, 0, 9'h15A);

    cur_req = "R4";
    mode_run(3'b011, 1, 9'h055);
    mode_run(3'b111, 1, 9'h0C7);
    mode_run(3'b111, 1, 9'h0C6);

    cur_req = "R5";
    @(negedge clk); frame_mode = 3'b001; par_odd = 0;
    for (int s = 0; s < 4; s++) begin
      stop_len = 2'(s);
      put(9'h081); put(9'h07E); drain();
    end

    cur_req = "R8";
    stop_len = 2'b01; cts_en = 1; cts_n = 1;
    put(9'h033);
    repeat (60) @(negedge clk);
    check("R8", "txd held", txd, 1'b1);
    check("R8", "tx_empty held", tx_empty, 1'b0);
    cts_n = 0;
    repeat (20) @(negedge clk);
    cts_n = 1;
    drain_cts: begin
      repeat (400) @(negedge clk);
    end
    check("R8", "frame completed", tx_empty, 1'b1);

    cur_req = "R7";
    for (int i = 0; i < 17; i++) put(9'(i * 13 + 1));
    check("R7", "tx_full", tx_full, 1'b1);
    cts_n = 0;
    @(negedge clk); wr_en = 1; wr_data = 9'h1FF;
    @(negedge clk); wr_en = 0;
    drain();

    cur_req = "R9";
    cts_n = 1;
    for (int i = 0; i < 5; i++) put(9'(i + 40));
    @(negedge clk); flush = 1; wr_en = 1; wr_data = 9'h0AA;
    @(negedge clk); flush = 0; wr_en = 0;
    check("R9", "tx_empty after flush", tx_empty, 1'b1);
    cts_n = 0;
    repeat (20) @(negedge clk);
    check("R9", "txd stays idle", txd, 1'b1);

    cur_req = "R10";
    cts_en = 0;
    @(negedge clk); wr_en = 1; wr_data = 9'h0F0;
    @(negedge clk); wr_en = 0;
    @(negedge clk);
    check("R10", "start bit", txd, 1'b0);
    stop_len = 2'b11; frame_mode = 3'b100;
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule